// File: doc/BRIEF.md
# Phase-Error Lock Monitor with Release Hysteresis

This block sits beside a phase-frequency detector and decides whether the synthesizer loop is in lock. It watches the detector's up and down correction pulses on a fast system clock. It measures how long the union of the two pulses stays active. When one pulse outlasts a width threshold, the monitor declares loss of lock on that same clock edge. The default threshold is 20 system cycles, which is about 200 ns at 100 MHz.

Releasing the flag is deliberately slow. The reference side marks the end of every comparison period with a one-cycle strobe. The flag drops only after a run of consecutive reference periods in which no pulse went over the threshold. Any over-width pulse restarts that run from zero.

The condition is presented in two ways. The first is an active-low pin that models an open-drain fail line: 0 means pulled low and 1 means released. The second is an active-high status bit that a register file can map. Both are plain level outputs with no handshake. No data stream passes through the block, so it has no valid/ready interface and needs no back-pressure rules.

Top module: `ool_detector`

## Requirements
- R1: During and after reset, before any reference strobe, `ool_status` is 1 and `lock_fail_n` is 0.
- R2: A pulse on `pfd_up` or `pfd_dn` that is active for at most THRESH consecutive clock samples (default 20) never sets the flag, and it does not disturb an already released flag.
- R3: When the pulse width goes over THRESH, `ool_status` becomes 1 on the clock edge that samples the (THRESH+1)-th consecutive active cycle.
- R4: Width is measured on the OR of `pfd_up` and `pfd_dn`. Simultaneous pulses count once, and an up pulse followed without a gap by a down pulse counts as one pulse.
- R5: The flag clears on the edge that samples the GOOD_CYCLES-th consecutive good `ref_tick` (default 6). A good tick ends a reference period that held no over-width sample, and that includes the tick cycle itself.
- R6: An over-width pulse that arrives while the release run is in progress sets the count back to zero, so GOOD_CYCLES fresh good periods are needed afterwards.
- R7: `lock_fail_n` is always the complement of `ool_status`.
- R8: A pulse held active for an unlimited time keeps the flag set across any number of reference strobes. The width count saturates and never wraps.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System measurement clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| pfd_up | input | 1 | Up correction pulse from the phase detector, synchronous to clk |
| pfd_dn | input | 1 | Down correction pulse from the phase detector, synchronous to clk |
| ref_tick | input | 1 | One-cycle strobe that closes each reference period |
| ool_status | output | 1 | Status bit, 1 while out of lock |
| lock_fail_n | output | 1 | Active-low fail line, 0 while out of lock |

## Verification
The properties assume three things about the inputs. The detector pulses are already synchronous to `clk`. `ref_tick` is a single-cycle strobe. Widths are judged from the cycle-accurate samples and not from analog timing. The stimulus changes every input on the falling clock edge and spaces reference strobes 41 cycles apart. It keeps ordinary pulses well inside one period, and only the saturation test deliberately holds a pulse across several strobes.

// File: rtl/ool_pkg.sv
package ool_pkg;

  // Lock decision held by the release stage.
  typedef enum logic {
    LOCK_HELD = 1'b0,
    LOCK_LOST = 1'b1
  } lock_state_e;

  // Bits needed to count from 0 to n inclusive.
  function automatic int unsigned cnt_bits(input int unsigned n);
    return (n < 2) ? 1 : $clog2(n + 1);
  endfunction

endpackage

// File: rtl/ool_width_meter.sv
// Measures the length of the current active phase-error pulse and flags
// every sample beyond the allowed width.
module ool_width_meter #(
  parameter int unsigned THRESH = 20
) (
  input  logic clk,
  input  logic rst_n,
  input  logic up_i,
  input  logic dn_i,
  output logic over_o
);
  import ool_pkg::*;

  localparam int unsigned WW = cnt_bits(THRESH);
  localparam logic [WW-1:0] LIMIT = WW'(THRESH);

  logic          active;
  logic [WW-1:0] run_q;

  // Union of both correction directions forms one pulse.
  assign active = up_i | dn_i;

  // Saturating run length: stops at LIMIT so long pulses never wrap.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      run_q <= '0;
    end else if (!active) begin
      run_q <= '0;
    end else if (run_q != LIMIT) begin
      run_q <= run_q + 1'b1;
    end
  end

  // LIMIT samples already seen and the current one is active too.
  assign over_o = active && (run_q == LIMIT);

endmodule

// File: rtl/ool_cycle_judge.sv
// Grades each reference period as good or bad.
module ool_cycle_judge (
  input  logic clk,
  input  logic rst_n,
  input  logic over_i,
  input  logic tick_i,
  output logic end_o,
  output logic good_o
);

  logic seen_bad_q;

  // Remembers an over-width sample until the period closes.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      seen_bad_q <= 1'b0;
    end else if (tick_i) begin
      seen_bad_q <= 1'b0;
    end else if (over_i) begin
      seen_bad_q <= 1'b1;
    end
  end

  assign end_o  = tick_i;
  assign good_o = !(seen_bad_q || over_i);

endmodule

// File: rtl/ool_hold_release.sv
// Sets the lock-lost state at once, clears it after a run of good periods.
module ool_hold_release #(
  parameter int unsigned GOOD_CYCLES = 6
) (
  input  logic clk,
  input  logic rst_n,
  input  logic over_i,
  input  logic end_i,
  input  logic good_i,
  output logic lost_o
);
  import ool_pkg::*;

  localparam int unsigned CW = cnt_bits(GOOD_CYCLES);
  localparam logic [CW-1:0] LAST = CW'(GOOD_CYCLES - 1);

  lock_state_e   state_q;
  logic [CW-1:0] run_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= LOCK_LOST;
      run_q   <= '0;
    end else if (over_i) begin
      state_q <= LOCK_LOST;
      run_q   <= '0;
    end else if (end_i && (state_q == LOCK_LOST)) begin
      if (!good_i) begin
        run_q <= '0;
      end else if (run_q == LAST) begin
        state_q <= LOCK_HELD;
        run_q   <= '0;
      end else begin
        run_q <= run_q + 1'b1;
      end
    end
  end

  assign lost_o = (state_q == LOCK_LOST);

endmodule

// File: rtl/ool_detector.sv
// Out-of-lock monitor: width meter, period judge and release hysteresis.
module ool_detector #(
  parameter int unsigned THRESH      = 20,
  parameter int unsigned GOOD_CYCLES = 6
) (
  input  logic clk,
  input  logic rst_n,
  input  logic pfd_up,
  input  logic pfd_dn,
  input  logic ref_tick,
  output logic ool_status,
  output logic lock_fail_n
);

  logic over;
  logic per_end;
  logic per_good;
  logic lost;

  ool_width_meter #(.THRESH(THRESH)) u_meter (
    .clk    (clk),
    .rst_n  (rst_n),
    .up_i   (pfd_up),
    .dn_i   (pfd_dn),
    .over_o (over)
  );

  ool_cycle_judge u_judge (
    .clk    (clk),
    .rst_n  (rst_n),
    .over_i (over),
    .tick_i (ref_tick),
    .end_o  (per_end),
    .good_o (per_good)
  );

  ool_hold_release #(.GOOD_CYCLES(GOOD_CYCLES)) u_release (
    .clk    (clk),
    .rst_n  (rst_n),
    .over_i (over),
    .end_i  (per_end),
    .good_i (per_good),
    .lost_o (lost)
  );

  // Status bit is active high; the fail line models an open-drain pull-down.
  assign ool_status  = lost;
  assign lock_fail_n = !lost;

endmodule

// File: rtl/ool_detector_chk.sv
module ool_detector_chk #(
  parameter int unsigned THRESH      = 20,
  parameter int unsigned GOOD_CYCLES = 6
) (
  input logic clk,
  input logic rst_n,
  input logic pfd_up,
  input logic pfd_dn,
  input logic ref_tick,
  input logic ool_status,
  input logic lock_fail_n
);
  import ool_pkg::*;

  localparam int unsigned MW = cnt_bits(THRESH);
  localparam int unsigned TW = cnt_bits(GOOD_CYCLES + 1);

  logic [MW-1:0] m_run;
  logic [TW-1:0] m_ticks;
  logic          m_over;

  assign m_over = (pfd_up || pfd_dn) && (int'(m_run) >= THRESH);

  // Independent observation counters for the properties.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_run   <= '0;
      m_ticks <= '0;
    end else begin
      if (!(pfd_up || pfd_dn)) m_run <= '0;
      else if (int'(m_run) < THRESH) m_run <= m_run + 1'b1;
      if (m_over) m_ticks <= '0;
      else if (ref_tick && int'(m_ticks) < GOOD_CYCLES + 1) m_ticks <= m_ticks + 1'b1;
    end
  end

  a_r3_long_pulse_flags: assert property (@(posedge clk) disable iff (!rst_n)
    m_over |=> ool_status);

  a_r2_short_keeps_clear: assert property (@(posedge clk) disable iff (!rst_n)
    (!ool_status && !m_over) |=> !ool_status);

  a_r5_release_on_tick: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(ool_status) |-> $past(ref_tick));

  a_r5_release_after_run: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(ool_status) |-> (int'($past(m_ticks)) >= GOOD_CYCLES - 1));

  a_r6_set_needs_long_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(ool_status) |-> $past(m_over));

  a_r7_pin_follows: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(ool_status) |-> $fell(lock_fail_n));

endmodule

bind ool_detector ool_detector_chk #(
  .THRESH      (THRESH),
  .GOOD_CYCLES (GOOD_CYCLES)
) u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .pfd_up      (pfd_up),
  .pfd_dn      (pfd_dn),
  .ref_tick    (ref_tick),
  .ool_status  (ool_status),
  .lock_fail_n (lock_fail_n)
);

// File: tb/ool_detector_tb.sv
module ool_detector_tb;

  localparam int THRESH  = 20;
  localparam int GOOD    = 6;
  localparam int PER_LEN = 40;

  // Line codes: 0 = up then down back to back, 1 = up, 2 = down, 3 = both.
  typedef struct packed {
    logic [7:0] w;
    logic [1:0] ln;
    logic       ex;
    logic [4:0] rq;
  } vec_t;

  localparam int NV = 22;
  localparam vec_t VEC [0:NV-1] = '{
    '{8'd5,  2'd1, 1'b1, 5'd5},  // R5 good period 1
    '{8'd5,  2'd1, 1'b1, 5'd5},  // R5 2
    '{8'd5,  2'd1, 1'b1, 5'd5},  // R5 3
    '{8'd5,  2'd1, 1'b1, 5'd5},  // R5 4
    '{8'd5,  2'd1, 1'b1, 5'd5},  // R5 5
    '{8'd20, 2'd2, 1'b0, 5'd2},  // R2 width at limit is good, 6th -> clear
    '{8'd8,  2'd1, 1'b0, 5'd2},  // R2 short pulse keeps clear
    '{8'd21, 2'd1, 1'b1, 5'd3},  // R3 one over limit
    '{8'd10, 2'd2, 1'b1, 5'd5},  // R5
    '{8'd10, 2'd2, 1'b1, 5'd5},
    '{8'd10, 2'd2, 1'b1, 5'd5},
    '{8'd10, 2'd2, 1'b1, 5'd5},
    '{8'd10, 2'd2, 1'b1, 5'd5},  // count at 5
    '{8'd21, 2'd2, 1'b1, 5'd6},  // R6 bad period restarts run
    '{8'd3,  2'd3, 1'b1, 5'd4},  // R4 both lines together
    '{8'd3,  2'd3, 1'b1, 5'd4},
    '{8'd3,  2'd3, 1'b1, 5'd4},
    '{8'd3,  2'd3, 1'b1, 5'd4},
    '{8'd3,  2'd3, 1'b1, 5'd6},  // R6 still held after 5 fresh
    '{8'd12, 2'd1, 1'b0, 5'd6},  // R6 6th fresh good -> clear
    '{8'd0,  2'd1, 1'b0, 5'd2},  // R2 idle period
    '{8'd24, 2'd0, 1'b1, 5'd4}   // R4 12 up + 12 down joined -> over
  };

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic pfd_up = 1'b0;
  logic pfd_dn = 1'b0;
  logic ref_tick = 1'b0;
  logic ool_status;
  logic lock_fail_n;

  int n_chk = 0;
  int n_bad = 0;
  bit done = 1'b0;

  always #5 clk = ~clk;

  ool_detector #(.THRESH(THRESH), .GOOD_CYCLES(GOOD)) u_dut (
    .clk         (clk),
    .rst_n       (rst_n),
    .pfd_up      (pfd_up),
    .pfd_dn      (pfd_dn),
    .ref_tick    (ref_tick),
    .ool_status  (ool_status),
    .lock_fail_n (lock_fail_n)
  );

  task automatic check(input logic exp, input string tag);
    n_chk++;
    if (ool_status !== exp || lock_fail_n !== !exp) begin
      n_bad++;
      $display("FAIL %s: ool_status=%0b lock_fail_n=%0b expected %0b/%0b",
               tag, ool_status, lock_fail_n, exp, !exp);
    end
  endtask

  // One reference period: pulse of width w on the chosen lines, tick last.
  task automatic run_period(input int w, input logic [1:0] ln);
    for (int i = 0; i < PER_LEN; i++) begin
      @(negedge clk);
      case (ln)
        2'd0: begin pfd_up = (i < w / 2); pfd_dn = (i >= w / 2) && (i < w); end
        2'd1: begin pfd_up = (i < w); pfd_dn = 1'b0; end
        2'd2: begin pfd_up = 1'b0; pfd_dn = (i < w); end
        default: begin pfd_up = (i < w); pfd_dn = (i < w); end
      endcase
      ref_tick = (i == PER_LEN - 1);
    end
    @(negedge clk);
    pfd_up = 1'b0;
    pfd_dn = 1'b0;
    ref_tick = 1'b0;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_bad++;
      $display("FAIL watchdog: run did not finish, expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    logic seen_clear;
    // R1 reset state
    repeat (3) @(negedge clk);
    check(1'b1, "R1 in reset");
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    check(1'b1, "R1 after reset");

    // Table walk, one reference period per vector (R7 checked in every compare)
    for (int v = 0; v < NV; v++) begin
      run_period(int'(VEC[v].w), VEC[v].ln);
      check(VEC[v].ex, $sformatf("R%0d vector %0d", VEC[v].rq, v));
    end

    // R5 release from the joined-pulse loss
    for (int k = 0; k < GOOD - 1; k++) run_period(0, 2'd1);
    check(1'b1, "R5 held after five good");
    run_period(0, 2'd1);
    check(1'b0, "R5 released on sixth good");

    // R3 the flag rises on the edge of the (THRESH+1)-th active sample
    @(negedge clk);
    pfd_dn = 1'b1;
    repeat (THRESH) @(negedge clk);
    check(1'b0, "R3 still clear after THRESH samples");
    @(negedge clk);
    check(1'b1, "R3 set at THRESH+1 samples");
    pfd_dn = 1'b0;

    // R8 pulse held across many ticks keeps the flag set
    seen_clear = 1'b0;
    for (int i = 0; i < 5 * PER_LEN; i++) begin
      @(negedge clk);
      if (ool_status !== 1'b1) seen_clear = 1'b1;
      pfd_up = 1'b1;
      ref_tick = (i % PER_LEN == PER_LEN - 1);
    end
    @(negedge clk);
    pfd_up = 1'b0;
    ref_tick = 1'b0;
    n_chk++;
    if (seen_clear) begin
      n_bad++;
      $display("FAIL R8: flag dropped during held pulse, expected 1 throughout");
    end
    check(1'b1, "R8 held after long pulse");
    for (int k = 0; k < GOOD - 1; k++) run_period(4, 2'd2);
    check(1'b1, "R8 no early release");
    run_period(4, 2'd2);
    check(1'b0, "R8 release after six good");

    // R2 short pulses on both lines leave a released flag untouched
    run_period(THRESH, 2'd3);
    check(1'b0, "R2 limit-width pulse on both lines");

    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

endmodule